// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sits between the core's power-mode request and the clock and regulator controls of a small system. Run mode keeps every clock running. A one-cycle entry request, with a mode code, moves the block into one of four low-power modes. Each mode sets its own mix of CPU clock gate, peripheral clock gate and main regulator enable. Each mode also has its own set of events that may wake it.

When a permitted wake event is seen, a wake-pending flag rises and the main regulator is switched on. The clock gates stay as they were in the low-power mode until a settling counter runs out. The counter is long when the regulator had been switched off and short when it had stayed on. Run mode then resumes. The active-low reset input forces run mode at once, from any state, without waiting for a clock edge.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset, cpu_clk_en, per_clk_en and main_reg_en are 1 and wake_pend is 0.
- R2: An entry request with enter_sel = 2'b00 (wait) stops only the CPU clock: cpu_clk_en=0, per_clk_en=1, main_reg_en=1 from the edge that samples the request. The value of reg_off_cfg has no effect on this mode.
- R3: An entry request with enter_sel = 2'b01 (active-halt) stops both clocks. The main regulator stays on when reg_off_cfg=0 and turns off when reg_off_cfg=1, as sampled with the request.
- R4: An entry request with enter_sel = 2'b10 (halt) clears all three enables. Whenever main_reg_en is 0, both clock enables are 0.
- R5: An entry request with enter_sel = 2'b11 is ignored and the block stays in run mode.
- R6: In wait mode, int_irq, ext_irq or awu_evt each start a wakeup.
- R7: In active-halt mode, awu_evt or ext_irq starts a wakeup, and int_irq alone is ignored.
- R8: In halt mode, only ext_irq starts a wakeup, and int_irq and awu_evt are ignored.
- R9: wake_pend is 1 from the edge that samples the wake event until run mode resumes. During that time main_reg_en=1, cpu_clk_en=0, and per_clk_en keeps the value it had in the low-power mode.
- R10: Run mode (cpu_clk_en=1) returns SETTLE_SHORT edges (default 2) after the wake-sampling edge for wait and regulator-on active-halt. It returns SETTLE_LONG edges (default 64) after that edge for regulator-off active-halt and halt.
- R11: An entry request made while wake_pend is 1 is ignored, and run mode follows the settling period.
- R12: Driving rst_n low returns all outputs to their run values immediately, from any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, forces run mode |
| enter_req | input | 1 | One-cycle request to enter a low-power mode |
| enter_sel | input | 2 | Mode code: 00 wait, 01 active-halt, 10 halt, 11 reserved |
| reg_off_cfg | input | 1 | Selects the regulator-off variant of active-halt |
| int_irq | input | 1 | Internal interrupt |
| ext_irq | input | 1 | External interrupt or event |
| awu_evt | input | 1 | Auto-wakeup timer event |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| main_reg_en | output | 1 | Main regulator enable |
| wake_pend | output | 1 | Wakeup accepted, settling in progress |

## Verification
A wrong latched mode shows at the ports on the edge right after the entry request, as a wrong mix of the three enables. A wrong wake qualification shows one edge after the stimulus: wake_pend either rises when it should stay low or stays low when it should rise. A settling counter loaded with the wrong length shows only when cpu_clk_en returns, up to SETTLE_LONG cycles later, so the bench counts the edges to that point exactly. A state machine that lets entry slip through during settling shows as cpu_clk_en staying low after the settling period ends.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  // mode codes presented on enter_sel
  localparam logic [1:0] SEL_WAIT  = 2'b00;
  localparam logic [1:0] SEL_AHALT = 2'b01;
  localparam logic [1:0] SEL_HALT  = 2'b10;
  localparam logic [1:0] SEL_RSVD  = 2'b11;

  // resolved low-power flavour, latched at entry
  typedef enum logic [1:0] {
    LP_WAIT   = 2'd0,
    LP_AH_ON  = 2'd1,
    LP_AH_OFF = 2'd2,
    LP_HALT   = 2'd3
  } lp_kind_e;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_SETTLE = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic cpu;
    logic per;
    logic reg_on;
  } gate_t;

  function automatic logic sel_valid(input logic [1:0] sel);
    return sel != SEL_RSVD;
  endfunction

  function automatic lp_kind_e resolve_kind(input logic [1:0] sel, input logic reg_off);
    lp_kind_e k;
    case (sel)
      SEL_WAIT:  k = LP_WAIT;
      SEL_AHALT: k = reg_off ? LP_AH_OFF : LP_AH_ON;
      default:   k = LP_HALT;
    endcase
    return k;
  endfunction

  // regulator was powered down in this flavour -> long settle
  function automatic logic reg_dropped(input lp_kind_e k);
    return (k == LP_AH_OFF) || (k == LP_HALT);
  endfunction

  // which sources may end the given flavour
  function automatic logic wake_hit(input lp_kind_e k, input logic int_i,
                                    input logic ext_i, input logic awu_i);
    logic hit;
    case (k)
      LP_WAIT:   hit = int_i | ext_i | awu_i;
      LP_AH_ON,
      LP_AH_OFF: hit = ext_i | awu_i;
      default:   hit = ext_i;
    endcase
    return hit;
  endfunction

  // clock/regulator mix while asleep
  function automatic gate_t sleep_gates(input lp_kind_e k);
    gate_t g;
    g.cpu    = 1'b0;
    g.per    = (k == LP_WAIT);
    g.reg_on = !reg_dropped(k);
    return g;
  endfunction

  function automatic gate_t gates_for(input seq_state_e st, input lp_kind_e k);
    gate_t g;
    case (st)
      ST_SLEEP:  g = sleep_gates(k);
      ST_SETTLE: begin
        g        = sleep_gates(k);
        g.reg_on = 1'b1;
      end
      default:   g = '{cpu: 1'b1, per: 1'b1, reg_on: 1'b1};
    endcase
    return g;
  endfunction

  // settle length in cycles
  function automatic int unsigned settle_cycles(input logic long_sel,
                                                input int unsigned long_n,
                                                input int unsigned short_n);
    return long_sel ? long_n : short_n;
  endfunction

endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
  import lpm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     armed,
  input  lp_kind_e kind,
  input  logic     int_irq,
  input  logic     ext_irq,
  input  logic     awu_evt,
  output logic     wake_evt
);

  logic src_hit;

  always_comb begin
    src_hit  = wake_hit(kind, int_irq, ext_irq, awu_evt);
    wake_evt = armed & src_hit;
  end

  // R6: any source ends wait
  p_wait_any_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && kind == LP_WAIT && (int_irq || ext_irq || awu_evt) |-> wake_evt);

  // R7: internal interrupt alone cannot end active-halt
  p_ahalt_int_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LP_AH_ON || kind == LP_AH_OFF) && !ext_irq && !awu_evt |-> !wake_evt);

  // R8: halt only ends on the external source
  p_halt_ext_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kind == LP_HALT && wake_evt |-> ext_irq);

endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer
  import lpm_pkg::*;
#(
  parameter int unsigned SETTLE_LONG  = 64,
  parameter int unsigned SETTLE_SHORT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic long_sel,
  output logic active,
  output logic done
);

  localparam int unsigned MAX_N = (SETTLE_LONG > SETTLE_SHORT) ? SETTLE_LONG : SETTLE_SHORT;
  localparam int unsigned CNT_W = $clog2(MAX_N + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    load_val = CNT_W'(settle_cycles(long_sel, SETTLE_LONG, SETTLE_SHORT) - 1);
    done     = active && (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val;
      active <= 1'b1;
    end else if (active) begin
      if (cnt_q == '0) active <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  // R10: an expired count releases the timer on the next edge
  p_expire_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !load |=> !active);

  // R10: a running count never stops early
  p_no_early_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    active && !done |=> active);

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_req,
  input  logic [1:0] enter_sel,
  input  logic       reg_off_cfg,
  input  logic       wake_evt,
  input  logic       settle_done,
  output seq_state_e state,
  output lp_kind_e   kind,
  output logic       settle_load,
  output logic       settle_long
);

  seq_state_e state_d;
  lp_kind_e   kind_d;
  logic       entry_ok;

  always_comb begin
    entry_ok    = enter_req && sel_valid(enter_sel);
    state_d     = state;
    kind_d      = kind;
    settle_load = 1'b0;
    settle_long = reg_dropped(kind);
    case (state)
      ST_RUN: begin
        if (entry_ok) begin
          state_d = ST_SLEEP;
          kind_d  = resolve_kind(enter_sel, reg_off_cfg);
        end
      end
      ST_SLEEP: begin
        if (wake_evt) begin
          state_d     = ST_SETTLE;
          settle_load = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (settle_done) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
      kind  <= LP_WAIT;
    end else begin
      state <= state_d;
      kind  <= kind_d;
    end
  end

  // R11: settling never moves straight back to sleep
  p_settle_no_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SETTLE |=> state != ST_SLEEP);

  // R5: reserved code leaves run mode untouched
  p_rsvd_stays_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_RUN && enter_sel == SEL_RSVD |=> state == ST_RUN);

  // R3: latched flavour is stable while asleep
  p_kind_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SLEEP |=> $stable(kind));

endmodule

// File: rtl/lpm_gate_decode.sv
module lpm_gate_decode
  import lpm_pkg::*;
(
  input  seq_state_e state,
  input  lp_kind_e   kind,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       main_reg_en,
  output logic       wake_pend
);

  gate_t g;

  always_comb begin
    g           = gates_for(state, kind);
    cpu_clk_en  = g.cpu;
    per_clk_en  = g.per;
    main_reg_en = g.reg_on;
    wake_pend   = (state == ST_SETTLE);
  end

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int unsigned SETTLE_LONG  = 64,
  parameter int unsigned SETTLE_SHORT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_req,
  input  logic [1:0] enter_sel,
  input  logic       reg_off_cfg,
  input  logic       int_irq,
  input  logic       ext_irq,
  input  logic       awu_evt,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       main_reg_en,
  output logic       wake_pend
);

  seq_state_e state;
  lp_kind_e   kind;
  logic       wake_evt;
  logic       settle_load;
  logic       settle_long;
  logic       settle_active;
  logic       settle_done;
  logic       armed;

  assign armed = (state == ST_SLEEP);

  lpm_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter_req   (enter_req),
    .enter_sel   (enter_sel),
    .reg_off_cfg (reg_off_cfg),
    .wake_evt    (wake_evt),
    .settle_done (settle_done),
    .state       (state),
    .kind        (kind),
    .settle_load (settle_load),
    .settle_long (settle_long)
  );

  lpm_wake_qual u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .armed    (armed),
    .kind     (kind),
    .int_irq  (int_irq),
    .ext_irq  (ext_irq),
    .awu_evt  (awu_evt),
    .wake_evt (wake_evt)
  );

  lpm_settle_timer #(
    .SETTLE_LONG  (SETTLE_LONG),
    .SETTLE_SHORT (SETTLE_SHORT)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (settle_load),
    .long_sel (settle_long),
    .active   (settle_active),
    .done     (settle_done)
  );

  lpm_gate_decode u_dec (
    .state       (state),
    .kind        (kind),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .main_reg_en (main_reg_en),
    .wake_pend   (wake_pend)
  );

  // R1: a running CPU implies everything else is up and nothing is pending
  p_run_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> per_clk_en && main_reg_en && !wake_pend);

  // R4: no clock runs with the regulator down
  p_reg_off_gates_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !main_reg_en |-> !cpu_clk_en && !per_clk_en);

  // R9: pending wake has regulator up and CPU still stopped
  p_pend_reg_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pend |-> main_reg_en && !cpu_clk_en);

  // R9: pending flag and settle timer agree
  p_pend_timer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pend == settle_active);

  // R9: peripheral gate frozen through settling
  p_pend_per_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pend && $past(wake_pend) |-> $stable(per_clk_en));

  // R11: pending wake ends only in run mode
  p_pend_to_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pend |=> wake_pend || cpu_clk_en);

endmodule

// File: tb/sim_lpm_sequencer.sv
module sim_lpm_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enter_req = 1'b0;
  logic [1:0] enter_sel = 2'b00;
  logic       reg_off_cfg = 1'b0;
  logic       int_irq = 1'b0;
  logic       ext_irq = 1'b0;
  logic       awu_evt = 1'b0;
  logic       cpu_clk_en, per_clk_en, main_reg_en, wake_pend;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  lpm_sequencer u0 (
    .clk, .rst_n, .enter_req, .enter_sel, .reg_off_cfg,
    .int_irq, .ext_irq, .awu_evt,
    .cpu_clk_en, .per_clk_en, .main_reg_en, .wake_pend
  );

  // vector: sel[17:16] cfg[15] int,ext,awu[14:12] ecpu,eper,ereg,ewake[11:8] delay[7:0]
  localparam int NV = 11;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 1'b0, 3'b100, 4'b0111, 8'd2},   // wait, internal irq
    {2'd0, 1'b1, 3'b001, 4'b0111, 8'd2},   // wait, cfg ignored, awu
    {2'd0, 1'b0, 3'b010, 4'b0111, 8'd2},   // wait, external
    {2'd1, 1'b0, 3'b001, 4'b0011, 8'd2},   // active-halt reg on, awu
    {2'd1, 1'b0, 3'b100, 4'b0010, 8'd0},   // active-halt, internal ignored
    {2'd1, 1'b1, 3'b010, 4'b0001, 8'd64},  // active-halt reg off, external
    {2'd1, 1'b1, 3'b001, 4'b0001, 8'd64},  // active-halt reg off, awu
    {2'd2, 1'b0, 3'b001, 4'b0000, 8'd0},   // halt, awu ignored
    {2'd2, 1'b1, 3'b100, 4'b0000, 8'd0},   // halt, internal ignored
    {2'd2, 1'b0, 3'b010, 4'b0001, 8'd64},  // halt, external
    {2'd3, 1'b0, 3'b111, 4'b1110, 8'd0}    // reserved code
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string gate_tag(input logic [1:0] sel);
    case (sel)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic string wake_tag(input logic [1:0] sel);
    case (sel)
      2'd0: return "R6";
      2'd1: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic enter(input logic [1:0] sel, input logic cfg);
    enter_req = 1'b1; enter_sel = sel; reg_off_cfg = cfg;
    @(negedge clk);
    enter_req = 1'b0;
  endtask

  task automatic pulse_wake(input logic [2:0] w);
    {int_irq, ext_irq, awu_evt} = w;
    @(negedge clk);
    {int_irq, ext_irq, awu_evt} = 3'b000;
  endtask

  // edges until cpu_clk_en returns, capped
  task automatic count_to_run(output int k);
    k = 0;
    while (!cpu_clk_en && k < 300) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int k;
    // R1: reset state
    do_reset();
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 per_clk_en", per_clk_en, 1);
    chk("R1 main_reg_en", main_reg_en, 1);
    chk("R1 wake_pend", wake_pend, 0);

    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      do_reset();
      enter(v[17:16], v[15]);
      chk(gate_tag(v[17:16]), cpu_clk_en, v[11]);
      chk(gate_tag(v[17:16]), per_clk_en, v[10]);
      chk(gate_tag(v[17:16]), main_reg_en, v[9]);
      if (v[17:16] == 2'd3) begin
        repeat (3) @(negedge clk);
        chk("R5 stays run", cpu_clk_en, 1);
      end else begin
        pulse_wake(v[14:12]);
        chk(wake_tag(v[17:16]), wake_pend, v[8]);
        if (v[8]) begin
          chk("R9 reg on while pending", main_reg_en, 1);
          chk("R9 per held while pending", per_clk_en, v[10]);
          count_to_run(k);
          chk("R10 settle edges", k, int'(v[7:0]));
          chk("R9 pending cleared", wake_pend, 0);
        end else begin
          repeat (3) @(negedge clk);
          chk(wake_tag(v[17:16]), wake_pend, 0);
          chk(wake_tag(v[17:16]), cpu_clk_en, 0);
        end
      end
    end

    // R11: entry request during settling is dropped
    do_reset();
    enter(2'd1, 1'b1);
    pulse_wake(3'b010);
    enter_req = 1'b1; enter_sel = 2'd0;
    repeat (3) @(negedge clk);
    enter_req = 1'b0;
    count_to_run(k);
    chk("R11 settle length kept", k, 64 - 3);
    repeat (3) @(negedge clk);
    chk("R11 still running", cpu_clk_en, 1);

    // R9: halt settling keeps peripherals off, regulator on
    do_reset();
    enter(2'd2, 1'b0);
    pulse_wake(3'b010);
    repeat (10) @(negedge clk);
    chk("R9 halt settle per", per_clk_en, 0);
    chk("R9 halt settle reg", main_reg_en, 1);
    chk("R9 halt settle pend", wake_pend, 1);

    // R3: cfg change while asleep does not alter the regulator
    do_reset();
    enter(2'd1, 1'b0);
    reg_off_cfg = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 latched cfg", main_reg_en, 1);

    // R12: asynchronous reset out of halt
    do_reset();
    enter(2'd2, 1'b1);
    chk("R12 asleep before reset", cpu_clk_en, 0);
    #2 rst_n = 1'b0;
    #1;
    chk("R12 cpu async", cpu_clk_en, 1);
    chk("R12 reg async", main_reg_en, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    summary();
    $finish;
  end

endmodule